// File: doc/BRIEF.md
# Fixed-Off-Time Current Chopper

This block sits between a current-sense comparator and one bridge's gate drivers. It turns a bridge on and leaves it driving until the comparator flag reports that the sensed coil current has reached its limit. It then turns the high side off and holds the bridge in short brake, with the low sides on, for a programmed number of ticks of an internal timing clock. When that time is up, the bridge is turned back on. A dead gap with every switch off separates each change between driving and braking.

The internal tick comes from a free-running divider on the master clock. The ratio is set by a 5-bit field. The off length is set by a 2-bit code. The two settings are independent, so the same chop-off time can be reached with a slow tick and a short count or with a fast tick and a long count. The comparator flag must be synchronous to the master clock. When `enable` is low, the bridge is idle, the divider is reset and the off-time count is cleared.

Top module: `offtime_chopper`

## Requirements
- R1: While `rst_n` is low, `hs_en` and `ls_en` are both low, whatever the other inputs do.
- R2: While enabled, the divider produces one tick every N master-clock cycles, where N is `div_sel`. A value of 0 is treated as 1. Counting master-clock edges from 0 at the first edge on which `enable` is sampled high, ticks fall on edge j whenever (j+1) is a multiple of N.
- R3: The off-length code `off_sel` selects K = 2 × (code + 1) ticks. Code 0 gives 2, code 1 gives 4, code 2 gives 6 and code 3 gives 8.
- R4: The off period ends on the (K+1)-th tick edge that comes strictly after the edge on which `limit_hit` was sampled in the drive phase. The first such tick starts the count, and K more ticks follow. `hs_en` rises DEAD_CYC edges after that tick edge.
- R5: After the turn-off gap, `ls_en` is high and `hs_en` is low. This brake state lasts until the off period ends.
- R6: Exactly DEAD_CYC master-clock cycles with both outputs low separate the fall of `hs_en` from the rise of `ls_en`. The same gap separates the fall of `ls_en` from the next rise of `hs_en`.
- R7: `limit_hit` acts only while `hs_en` is high. Without it, the drive phase continues. It is ignored during the gaps, during brake and while the block is disabled.
- R8: When `enable` is sampled low, both outputs are low after that edge and the off-time count is cleared. On re-enable, the block starts again from the turn-on gap.
- R9: `hs_en` and `ls_en` are never high in the same cycle.
- R10: After `enable` is first sampled high at edge 0, `hs_en` rises after edge DEAD_CYC.

Parameter defaults are DIV_W = 5, OFF_W = 2 and DEAD_CYC = 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run control; low forces the idle state |
| limit_hit | input | 1 | Comparator flag: the sensed current has reached the limit |
| div_sel | input | DIV_W | Tick divide ratio, 1 to 31 (0 acts as 1) |
| off_sel | input | OFF_W | Off-length code, K = 2 × (code + 1) ticks |
| hs_en | output | 1 | High-side gate enable (drive phase) |
| ls_en | output | 1 | Low-side gate enable (short-brake phase) |

## Verification
Two events can land on the same master-clock edge: a divider tick and the sampling of `limit_hit` that ends the drive phase. That tick must not be counted as the first tick of the off period. The bench provokes this by sweeping every divide ratio, every off code and several drive lengths, so the limit lands on every tick phase, including ratio 1 where each edge is a tick. It judges the result by the exact cycle on which `hs_en` returns, which the bench computes from its own edge count. It also checks the number of brake and dead cycles in each off period.

// File: rtl/chop_pkg.sv
// Package: shared phase encoding for the fixed-off-time chopper.
// Assumes: all users compile this file first.
package chop_pkg;

    // Bridge phase of one chopper channel
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,  // disabled, all switches off
        PH_GAP_ON  = 3'd1,  // dead gap before driving
        PH_DRIVE   = 3'd2,  // high side on, current rising
        PH_GAP_OFF = 3'd3,  // dead gap before braking
        PH_BRAKE   = 3'd4   // short brake, low sides on
    } phase_t;

endpackage

// File: rtl/chop_tick_div.sv
// Module: chop_tick_div
// Derives the internal timing tick from the master clock by dividing by a
// programmable ratio. A ratio of 0 acts as 1. The divider is held at zero
// while run is low, so the first tick comes N edges after run is sampled high.
// Assumes: ratio is quasi-static; a lowered ratio takes effect at once via >=.
module chop_tick_div #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_val;

    // Terminal count of the divider (ratio-1, with 0 mapped to divide-by-1)
    always_comb begin
        if (ratio == '0)
            last_val = '0;
        else
            last_val = ratio - DIV_W'(1);
    end

    // Tick is high during the cycle in which the divider sits at its terminal count
    assign tick = run && (cnt_q >= last_val);

    // Divider counter: cleared when idle, wraps at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || (cnt_q >= last_val))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end

endmodule

// File: rtl/chop_off_timer.sv
// Module: chop_off_timer
// Counts internal ticks during the off period. The off period ends on the
// tick that follows K counted ticks, with K = 2*(code+1). The first tick seen
// while active starts the count.
// Assumes: active is high only from the cycle after high-side turn-off.
module chop_off_timer #(
    parameter int OFF_W = 2,
    localparam int CNT_W = OFF_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic [OFF_W-1:0] off_code,
    output logic             done
);

    logic [CNT_W-1:0] seen_q;
    logic [CNT_W-1:0] target;

    // Number of ticks that must be seen before the ending tick
    assign target = CNT_W'({off_code, 1'b0}) + CNT_W'(2);

    // End of off period: a tick arrives once the target has been reached
    assign done = active && tick && (seen_q >= target);

    // Tick counter: cleared outside the off period and when it completes
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= '0;
        else if (!active || done)
            seen_q <= '0;
        else if (tick)
            seen_q <= seen_q + CNT_W'(1);
    end

endmodule

// File: rtl/chop_phase_fsm.sv
// Module: chop_phase_fsm
// Sequences the bridge through turn-on gap, drive, turn-off gap and brake.
// Gate enables are registered from the next phase, so they are glitch-free
// and change on the same edge as the phase.
// Assumes: limit_hit is synchronous to clk; DEAD_CYC >= 1.
module chop_phase_fsm
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 2,
    localparam int GAP_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   limit_hit,
    input  logic   off_done,
    output phase_t phase,
    output logic   hs_q,
    output logic   ls_q
);

    phase_t            phase_n;
    logic [GAP_W-1:0]  gap_q;
    logic              in_gap;
    logic              gap_end;

    assign in_gap  = (phase == PH_GAP_ON) || (phase == PH_GAP_OFF);
    assign gap_end = in_gap && (gap_q == GAP_W'(DEAD_CYC - 1));

    // Next-phase decode; disable overrides every other condition
    always_comb begin
        phase_n = phase;
        if (!enable) begin
            phase_n = PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:    phase_n = PH_GAP_ON;
                PH_GAP_ON:  if (gap_end) phase_n = PH_DRIVE;
                PH_DRIVE:   if (limit_hit) phase_n = PH_GAP_OFF;
                PH_GAP_OFF: begin
                    if (off_done)
                        phase_n = PH_GAP_ON;
                    else if (gap_end)
                        phase_n = PH_BRAKE;
                end
                PH_BRAKE:   if (off_done) phase_n = PH_GAP_ON;
                default:    phase_n = PH_IDLE;
            endcase
        end
    end

    // Phase register and registered gate enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            hs_q  <= 1'b0;
            ls_q  <= 1'b0;
        end else begin
            phase <= phase_n;
            hs_q  <= (phase_n == PH_DRIVE);
            ls_q  <= (phase_n == PH_BRAKE);
        end
    end

    // Dead-gap cycle counter, restarted on every phase change
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (phase_n != phase)
            gap_q <= '0;
        else if (in_gap)
            gap_q <= gap_q + GAP_W'(1);
    end

endmodule

// File: rtl/offtime_chopper.sv
// Module: offtime_chopper (top)
// One constant-current chopper channel: the bridge drives until the external
// comparator flags the current limit. It then brakes for a tick-counted off
// time, and dead gaps separate every switching change.
// Assumes: limit_hit already synchronised to clk; comparator/DAC are external.
module offtime_chopper
    import chop_pkg::*;
#(
    parameter int DIV_W    = 5,
    parameter int OFF_W    = 2,
    parameter int DEAD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             limit_hit,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [OFF_W-1:0] off_sel,
    output logic             hs_en,
    output logic             ls_en
);

    logic   tick;
    logic   off_active;
    logic   off_done;
    phase_t phase;

    // Off-time counting spans the turn-off gap and the brake phase
    assign off_active = enable && ((phase == PH_GAP_OFF) || (phase == PH_BRAKE));

    chop_tick_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .ratio (div_sel),
        .tick  (tick)
    );

    chop_off_timer #(
        .OFF_W (OFF_W)
    ) u_off (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (off_active),
        .tick     (tick),
        .off_code (off_sel),
        .done     (off_done)
    );

    chop_phase_fsm #(
        .DEAD_CYC (DEAD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .limit_hit (limit_hit),
        .off_done  (off_done),
        .phase     (phase),
        .hs_q      (hs_en),
        .ls_q      (ls_en)
    );

endmodule

// File: rtl/offtime_chopper_chk.sv
// Module: offtime_chopper_chk
// Port-level protocol checks for the chopper, bound into every instance.
module offtime_chopper_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic limit_hit,
    input logic hs_en,
    input logic ls_en
);

    // R1
    reset_off_chk: assert property (@(posedge clk)
        !rst_n |=> (!hs_en && !ls_en));

    // R9
    gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R6
    gap_before_brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(hs_en));

    // R6
    gap_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> !$past(ls_en));

    // R8
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hs_en && !ls_en));

    // R7
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && !limit_hit && enable) |=> hs_en);

endmodule

bind offtime_chopper offtime_chopper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .limit_hit (limit_hit),
    .hs_en     (hs_en),
    .ls_en     (ls_en)
);

// File: tb/offtime_chopper_test.sv
// Bench: sweeps every divide ratio and off code; expected timing comes from
// the bench's own edge count since enable.
module offtime_chopper_test;

    localparam int CLK_PERIOD = 10;
    localparam int D = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       limit_hit = 1'b0;
    logic [4:0] div_sel = 5'd1;
    logic [1:0] off_sel = 2'd0;
    logic       hs_en;
    logic       ls_en;

    int checks = 0;
    int fails = 0;
    int eidx = 0;
    int overlap = 0;
    int cyc = 0;

    offtime_chopper #(.DIV_W(5), .OFF_W(2), .DEAD_CYC(D)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .limit_hit (limit_hit),
        .div_sel   (div_sel),
        .off_sel   (off_sel),
        .hs_en     (hs_en),
        .ls_en     (ls_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edges elapsed since enable was first sampled high
    always @(posedge clk) eidx <= enable ? eidx + 1 : 0;

    // Exclusivity monitor
    always @(negedge clk) if (rst_n && hs_en && ls_en) overlap++;

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=%0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Enable with the given settings and check the start-up gap (R10)
    task automatic start_up(input int d, input int o);
        int waitc;
        @(negedge clk);
        enable = 1'b0;
        limit_hit = 1'b0;
        @(negedge clk);
        div_sel = d[4:0];
        off_sel = o[1:0];
        enable = 1'b1;
        @(negedge clk);
        waitc = 0;
        while (!hs_en && waitc < 50) begin
            @(negedge clk);
            waitc++;
        end
        check(eidx == D + 1, "R10 first drive after turn-on gap", eidx, D + 1);
    endtask

    // One limit event followed by a full off period, timed against the model
    task automatic off_cycle(input int d, input int o, input int w);
        int n, k, e_l, e_done, seen, j, brk, zero, cnt;
        n = (d == 0) ? 1 : d;
        k = 2 * (o + 1);
        repeat (w) @(negedge clk);
        check(hs_en == 1'b1, "R7 drive holds without limit", hs_en, 1);
        e_l = eidx;
        limit_hit = 1'b1;
        @(negedge clk);
        limit_hit = 1'b0;
        seen = 0;
        e_done = -1;
        j = e_l + 1;
        while (e_done < 0) begin
            if (((j + 1) % n) == 0) begin
                seen++;
                if (seen == k + 1) e_done = j;
            end
            j++;
        end
        brk = 0;
        zero = 0;
        cnt = 0;
        while (!hs_en && cnt < 2000) begin
            if (ls_en) brk++;
            else zero++;
            @(negedge clk);
            cnt++;
        end
        // R4 off end, with R2 divide ratio and R3 off code
        check(eidx == e_done + D + 1, "R4 drive resumes (R2 ratio, R3 code)", eidx, e_done + D + 1);
        check(brk == e_done - e_l - D, "R5 brake length", brk, e_done - e_l - D);
        check(zero == 2 * D, "R6 dead cycles per off period", zero, 2 * D);
    endtask

    initial begin
        int waitc;
        // R1: reset holds outputs low
        enable = 1'b1;
        limit_hit = 1'b1;
        repeat (5) @(negedge clk);
        check(!hs_en && !ls_en, "R1 outputs low in reset", {hs_en, ls_en}, 0);
        enable = 1'b0;
        limit_hit = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!hs_en && !ls_en, "R1 idle after reset", {hs_en, ls_en}, 0);

        // R7: limit held through the turn-on gap is ignored
        @(negedge clk);
        div_sel = 5'd4;
        off_sel = 2'd1;
        enable = 1'b1;
        limit_hit = 1'b1;
        repeat (D) @(negedge clk);
        limit_hit = 1'b0;
        @(negedge clk);
        check(hs_en == 1'b1, "R7 limit in gap ignored", hs_en, 1);
        repeat (3) @(negedge clk);
        check(hs_en == 1'b1, "R7 drive continues", hs_en, 1);

        // Sweep: every ratio (0 acts as 1), every off code, varied drive length
        for (int d = 0; d < 32; d++) begin
            for (int o = 0; o < 4; o++) begin
                start_up(d, o);
                off_cycle(d, o, (d + o) % 5);
            end
        end

        // R8: disable during brake, outputs drop and restart is clean
        start_up(3, 3);
        @(negedge clk);
        limit_hit = 1'b1;
        @(negedge clk);
        limit_hit = 1'b0;
        waitc = 0;
        while (!ls_en && waitc < 50) begin
            @(negedge clk);
            waitc++;
        end
        check(ls_en == 1'b1, "R5 brake reached", ls_en, 1);
        enable = 1'b0;
        @(negedge clk);
        check(!hs_en && !ls_en, "R8 outputs low after disable", {hs_en, ls_en}, 0);
        limit_hit = 1'b1;
        repeat (3) @(negedge clk);
        check(!hs_en && !ls_en, "R8 limit ignored while disabled", {hs_en, ls_en}, 0);
        limit_hit = 1'b0;
        div_sel = 5'd5;
        off_sel = 2'd2;
        enable = 1'b1;
        @(negedge clk);
        waitc = 0;
        while (!hs_en && waitc < 50) begin
            @(negedge clk);
            waitc++;
        end
        check(eidx == D + 1, "R8 restart through turn-on gap", eidx, D + 1);
        off_cycle(5, 2, 2);

        check(overlap == 0, "R9 gates never both on", overlap, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule